// File: doc/BRIEF.md
# Low Power Mode Controller

This block steps a processor core between run mode and three graded low-power modes: doze, nap and sleep. Entry starts from run mode. It happens when the core's power-down request input is high and the matching enable bit in a 32-bit control word is set. If several enables are set, the deepest mode is chosen. Each mode keeps a different set of activity enables high. Doze keeps the clock generator, the time base and snoop logic running. Nap stops snooping. Sleep stops all three.

Sleep uses a handshake with system logic. The controller first raises a quiesce request and waits for a quiesce acknowledge. A fixed number of cycles after the acknowledge is sampled, it enters sleep. A wakeup input takes the controller back to run mode from any mode, including a sleep that is still pending. A 3-bit status output gives the current mode.

Top module: `lpm_ctrl`

## Requirements
- R1: The controller leaves run mode only on a clock edge where `pwr_dn` is 1, `wake` is 0 and at least one mode enable is set. Without these conditions `mode_o` stays 0 (run).
- R2: The mode enables are read from `ctrl_word`, with bit 0 as the most significant bit. Bit 8 enables doze, bit 9 enables nap and bit 10 enables sleep. No other bit of `ctrl_word` affects the controller.
- R3: When more than one enable is set at entry, sleep is chosen over nap and nap is chosen over doze.
- R4: In doze, `mode_o` is 1 and `clk_en`, `tb_en` and `snoop_en` are all 1.
- R5: In nap, `mode_o` is 2, `clk_en` and `tb_en` are 1, and `snoop_en` is 0.
- R6: On sleep entry the controller first goes to sleep-pending (`mode_o` = 3) with `qreq` = 1. It stays there, with all three activity enables at 1, until `qack` is sampled high.
- R7: Sleep (`mode_o` = 4) begins exactly ENTRY_DLY clock edges after the edge that samples `qack` high. In sleep, `clk_en`, `tb_en` and `snoop_en` are 0 and `qreq` stays 1.
- R8: A `wake` during sleep-pending cancels the entry, both before and after the acknowledge. On the next edge, `mode_o` is 0 and `qreq` is 0.
- R9: From any mode other than run, `wake` returns the controller to run in one edge. It restores all three activity enables to 1 and drops `qreq` to 0.
- R10: After reset, `mode_o` is 0, `qreq` is 0 and all three activity enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Control word carrying the mode enables at bits 8, 9, 10 (bit 0 is MSB) |
| pwr_dn | input | 1 | Power-down request from the machine state |
| wake | input | 1 | Wakeup event, returns to run mode |
| qack | input | 1 | Quiesce acknowledge from system logic |
| qreq | output | 1 | Quiesce request to system logic |
| clk_en | output | 1 | Clock generator keep-alive |
| tb_en | output | 1 | Time base keep-alive |
| snoop_en | output | 1 | Snoop logic keep-alive |
| mode_o | output | 3 | Mode: 0 run, 1 doze, 2 nap, 3 sleep-pending, 4 sleep |

## Verification
Some rules are checked by assertions on every cycle. These are: no entry without a power-down request, the gating sets of nap and sleep, that `qreq` rises only on the way into sleep-pending, and that wake returns to run in one edge. The bench scenarios are needed for the rest. They show the exact count of ENTRY_DLY cycles from the acknowledge to sleep, the priority among several enables, and that the other bits of the control word have no effect. They also show that a wake cancels a pending sleep both before and after the acknowledge.

// File: rtl/lpm_ctrl.sv
`timescale 1ns/1ps
module lpm_ctrl #(
  parameter int ENTRY_DLY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [0:31] ctrl_word,
  input  logic        pwr_dn,
  input  logic        wake,
  input  logic        qack,
  output logic        qreq,
  output logic        clk_en,
  output logic        tb_en,
  output logic        snoop_en,
  output logic [2:0]  mode_o
);
  localparam int CW = $clog2(ENTRY_DLY + 1);

  typedef enum logic [2:0] {
    S_RUN = 3'd0, S_DOZE = 3'd1, S_NAP = 3'd2, S_PEND = 3'd3, S_SLEEP = 3'd4
  } state_t;

  state_t        state;
  logic          acked;
  logic [CW-1:0] cnt;

  wire en_doze  = ctrl_word[8];
  wire en_nap   = ctrl_word[9];
  wire en_sleep = ctrl_word[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RUN;
      acked <= 1'b0;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_RUN: if (pwr_dn && !wake) begin
          if (en_sleep) begin
            state <= S_PEND;
            acked <= 1'b0;
          end else if (en_nap)  state <= S_NAP;
          else if (en_doze)     state <= S_DOZE;
        end
        S_PEND: begin
          if (wake) begin
            state <= S_RUN;
            acked <= 1'b0;
          end else if (!acked) begin
            if (qack) begin
              acked <= 1'b1;
              cnt   <= CW'(1);
            end
          end else if (cnt == CW'(ENTRY_DLY)) begin
            state <= S_SLEEP;
            acked <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DOZE, S_NAP, S_SLEEP: if (wake) state <= S_RUN;
        default: state <= S_RUN;
      endcase
    end
  end

  assign mode_o   = state;
  assign qreq     = (state == S_PEND) || (state == S_SLEEP);
  assign clk_en   = (state != S_SLEEP);
  assign tb_en    = (state != S_SLEEP);
  assign snoop_en = (state != S_NAP) && (state != S_SLEEP);

  a_r1_no_entry_without_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0 && !pwr_dn) |=> mode_o == 3'd0);

  a_r5_nap_gating: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2) |-> (clk_en && tb_en && !snoop_en));

  a_r7_sleep_gating: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4) |-> (!clk_en && !tb_en && !snoop_en && qreq));

  a_r7_sleep_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && $past(mode_o) != 3'd4) |-> $past(mode_o) == 3'd3);

  a_r6_qreq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qreq) |-> (mode_o == 3'd3 && $past(mode_o) == 3'd0));

  a_r9_wake_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && mode_o != 3'd0) |=> (mode_o == 3'd0 && !qreq && clk_en && tb_en && snoop_en));
endmodule

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_ctrl_bench;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [0:31] ctrl_word = '0;
  logic        pwr_dn = 1'b0, wake = 1'b0, qack = 1'b0;
  logic        qreq, clk_en, tb_en, snoop_en;
  logic [2:0]  mode_o;

  lpm_ctrl #(.ENTRY_DLY(D)) u_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .pwr_dn(pwr_dn),
    .wake(wake), .qack(qack), .qreq(qreq), .clk_en(clk_en), .tb_en(tb_en),
    .snoop_en(snoop_en), .mode_o(mode_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [2:0] m;
    logic       q, c, t, s;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   vectors = 0;
  int   misses  = 0;
  bit   done    = 0;

  int em = 0;
  bit ewait = 0;
  int ecnt = 0;

  function automatic logic [0:31] cwd(bit d, bit n, bit s, logic [0:31] noise);
    logic [0:31] w;
    w = noise;
    w[8] = d; w[9] = n; w[10] = s;
    return w;
  endfunction

  task automatic drv(bit pd, logic [0:31] cw, bit wk, bit ak, string tag);
    exp_t e;
    @(negedge clk);
    pwr_dn = pd; ctrl_word = cw; wake = wk; qack = ak;
    if (em == 0) begin
      if (pd && !wk) begin
        if (cw[10]) begin em = 3; ewait = 1; end
        else if (cw[9]) em = 2;
        else if (cw[8]) em = 1;
      end
    end else if (wk) begin
      em = 0; ewait = 0;
    end else if (em == 3) begin
      if (ewait) begin
        if (ak) begin ewait = 0; ecnt = 1; end
      end else if (ecnt == D) em = 4;
      else ecnt++;
    end
    e.m = 3'(em);
    e.q = (em >= 3);
    e.c = (em != 4);
    e.t = (em != 4);
    e.s = !(em == 2 || em == 4);
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        vectors++;
        if ({mode_o, qreq, clk_en, tb_en, snoop_en} !== {e.m, e.q, e.c, e.t, e.s}) begin
          misses++;
          $display("FAIL %s: got mode=%0d q=%b c=%b t=%b s=%b, expected mode=%0d q=%b c=%b t=%b s=%b",
                   e.tag, mode_o, qreq, clk_en, tb_en, snoop_en, e.m, e.q, e.c, e.t, e.s);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if ({mode_o, qreq, clk_en, tb_en, snoop_en} !== {3'd0, 1'b0, 1'b1, 1'b1, 1'b1}) begin
      misses++;
      $display("FAIL R10: got mode=%0d q=%b c=%b t=%b s=%b, expected mode=0 q=0 c=1 t=1 s=1",
               mode_o, qreq, clk_en, tb_en, snoop_en);
    end
    rst_n = 1'b1;

    // R1: enables set but no power-down; power-down with no enables; wake blocks entry
    drv(0, cwd(1, 1, 1, '0), 0, 0, "R1");
    drv(1, cwd(0, 0, 0, '0), 0, 0, "R1");
    drv(1, cwd(1, 0, 0, '0), 1, 0, "R1");
    // R2: every other bit set, enables clear
    drv(1, cwd(0, 0, 0, '1), 0, 0, "R2");
    drv(1, cwd(0, 0, 0, 32'h5A5A_A5A5), 0, 0, "R2");
    // R4 doze, then R9 wake
    drv(1, cwd(1, 0, 0, '0), 0, 0, "R4");
    drv(0, cwd(1, 0, 0, '0), 0, 1, "R4");
    drv(0, '0, 1, 0, "R9");
    // R5 nap, R3 nap over doze
    drv(1, cwd(1, 1, 0, '1), 0, 0, "R3");
    drv(0, '0, 0, 0, "R5");
    drv(0, '0, 1, 0, "R9");
    // R3 all three -> sleep pending, R6 holds without ack
    drv(1, cwd(1, 1, 1, '0), 0, 0, "R3");
    drv(0, '0, 0, 0, "R6");
    drv(1, '0, 0, 0, "R6");
    // R8 wake before ack
    drv(0, '0, 1, 0, "R8");
    // R7 full sleep entry
    drv(1, cwd(0, 0, 1, '0), 0, 0, "R6");
    drv(0, '0, 0, 1, "R7");
    for (int i = 0; i < D; i++) drv(0, '0, 0, 0, "R7");
    drv(0, '0, 0, 1, "R7");
    drv(0, '0, 1, 0, "R9");
    // R8 wake after ack, during count
    drv(1, cwd(0, 0, 1, '0), 0, 0, "R6");
    drv(0, '0, 0, 1, "R7");
    drv(0, '0, 0, 0, "R7");
    drv(0, '0, 1, 0, "R8");
    drv(0, '0, 0, 0, "R8");
    // qack ignored while in run
    drv(0, cwd(0, 0, 1, '0), 0, 1, "R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule